// File: doc/BRIEF.md
# Overcurrent Alarm Filter and Counter

This block watches an external overcurrent alarm pin. It turns the pin into two control outputs. The first is a throttle request for a downstream clock throttling arbiter. The second is a sticky interrupt.

The raw pin is first corrected for the selected active level. It is then brought into the clock domain through a two-stage synchronizer. The throttle request follows the synchronized alarm level. It stays asserted for a programmable hold time after the alarm goes away. That hold time is given in microseconds and scaled by a parameterized number of clocks per microsecond.

Each inactive-to-active transition of the synchronized alarm is one event. Events are tallied, and the interrupt is raised once the tally reaches a programmed limit. A quiet-window timer discards the tally when no event has arrived for a programmed number of clocks, and then re-arms. All pins are plain control and status levels: no data flows through the block, so it has no valid/ready handshake. Configuration inputs are expected to be static while alarms are being counted.

Top module: `oc_alarm_guard`

## Requirements
- R1: With `cfg_active_low`=0 a high `alarm_raw` is an active alarm; with `cfg_active_low`=1 a low `alarm_raw` is an active alarm. While the synchronized alarm is active, `throttle_req` is 1.
- R2: `throttle_req` rises at the second rising clock edge after `alarm_raw` becomes active. No event is seen before that edge.
- R3: An event is one inactive-to-active transition of the synchronized alarm. The tally saturates at its maximum. With `cfg_irq_en`=1 and `cfg_count_limit`=N≥1, `irq` rises one clock after the Nth event is detected.
- R4: With `cfg_count_limit`=0, as with 1, every event raises `irq` when `cfg_irq_en`=1.
- R5: With `cfg_irq_en`=0, `irq` never rises, but `throttle_req` still follows the alarm.
- R6: `irq` stays at 1 until a cycle with `irq_clear`=1. That cycle also zeroes the tally. An event arriving in the same cycle is counted as the first event of a fresh tally.
- R7: When `cfg_filter_len`=L≠0 and the tally is nonzero, the tally is cleared L clocks after the last event. Every event restarts this window. `cfg_filter_len`=0 disables the clearing.
- R8: After the synchronized alarm goes inactive, `throttle_req` stays 1 for exactly `cfg_hold_us`×`CYC_PER_US` further clocks. With `cfg_hold_us`=0 it drops together with the synchronized alarm.
- R9: During and right after reset, `throttle_req` and `irq` are 0 and the tally, timers and synchronizer are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_raw | input | 1 | Asynchronous overcurrent alarm pin |
| cfg_active_low | input | 1 | 1: alarm is active when the pin is low |
| cfg_irq_en | input | 1 | Enables interrupt generation |
| cfg_count_limit | input | COUNT_W | Events needed to raise the interrupt (0 acts as 1) |
| cfg_filter_len | input | FILT_W | Quiet window in clocks before the tally is cleared (0 = never) |
| cfg_hold_us | input | HOLD_US_W | Throttle hold after alarm release, in microseconds |
| irq_clear | input | 1 | Clears the interrupt and the tally |
| throttle_req | output | 1 | Throttle request to the arbiter |
| irq | output | 1 | Sticky overcurrent interrupt |

## Verification
The alarm is driven in both polarities as isolated pulses. This separates level tracking and synchronizer latency from the event tally. Pulse trains with gaps shorter and longer than the quiet window show whether the window clears the tally and whether each event restarts it. Limits of 0, 1 and 3 are tried, with the interrupt enabled and disabled, with clears in between, and with a clear landing on the same cycle as an event. Long alarms with nonzero hold times measure the release tail cycle by cycle. A pseudo-random toggling section then mixes all of these against the reference model.

// File: rtl/oc_guard_pkg.sv
package oc_guard_pkg;
  // Synchronized view of the alarm pin
  typedef struct packed {
    logic level;  // alarm active after polarity and synchronizer
    logic rise;   // one-cycle strobe on inactive-to-active transition
  } oc_sense_t;
endpackage

// File: rtl/oc_alarm_sync.sv
module oc_alarm_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alarm_raw,
  input  logic                   active_low,
  output oc_guard_pkg::oc_sense_t sense
);
  logic [SYNC_STAGES-1:0] stage_q;
  logic                   prev_q;
  logic                   pol;

  // polarity folded in before the first flop so reset means "inactive"
  assign pol = alarm_raw ^ active_low;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= pol;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stage_q[SYNC_STAGES-1];

  assign sense.level = stage_q[SYNC_STAGES-1];
  assign sense.rise  = stage_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/oc_event_tally.sv
module oc_event_tally #(
  parameter int COUNT_W = 8,
  parameter int FILT_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise,
  input  logic               irq_en,
  input  logic [COUNT_W-1:0] limit,
  input  logic [FILT_W-1:0]  filt_len,
  input  logic               irq_clear,
  output logic               irq
);
  logic [COUNT_W-1:0] cnt_q, cnt_d, cnt_base, cnt_inc;
  logic [FILT_W-1:0]  ft_q, ft_d, ft_inc;
  logic               irq_q, irq_d;

  assign cnt_base = irq_clear ? '0 : cnt_q;
  assign cnt_inc  = (cnt_base == '1) ? cnt_base : cnt_base + 1'b1;
  assign ft_inc   = ft_q + 1'b1;

  always_comb begin
    cnt_d = cnt_base;
    ft_d  = ft_q;
    irq_d = irq_q & ~irq_clear;
    if (rise) begin
      cnt_d = cnt_inc;
      ft_d  = '0;                     // each event restarts the window
      if (irq_en && (cnt_inc >= limit)) irq_d = 1'b1;
    end else if (irq_clear) begin
      ft_d = '0;
    end else if ((cnt_base != '0) && (filt_len != '0)) begin
      if (ft_inc == filt_len) begin   // quiet window expired: drop and re-arm
        cnt_d = '0;
        ft_d  = '0;
      end else begin
        ft_d = ft_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      ft_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ft_q  <= ft_d;
      irq_q <= irq_d;
    end

  assign irq = irq_q;
endmodule

// File: rtl/oc_throttle_hold.sv
module oc_throttle_hold #(
  parameter int HOLD_US_W  = 8,
  parameter int CYC_PER_US = 125
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 level,
  input  logic [HOLD_US_W-1:0] hold_us,
  output logic                 throttle
);
  localparam int HOLD_CYC_W = HOLD_US_W + $clog2(CYC_PER_US + 1);

  logic [HOLD_CYC_W-1:0] tail_q, tail_load;

  assign tail_load = HOLD_CYC_W'(hold_us) * HOLD_CYC_W'(CYC_PER_US);

  // reloaded every active cycle, counts down once the alarm is gone
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              tail_q <= '0;
    else if (level)          tail_q <= tail_load;
    else if (tail_q != '0)   tail_q <= tail_q - 1'b1;

  assign throttle = level | (tail_q != '0);
endmodule

// File: rtl/oc_alarm_guard.sv
module oc_alarm_guard #(
  parameter int COUNT_W    = 8,
  parameter int FILT_W     = 16,
  parameter int HOLD_US_W  = 8,
  parameter int CYC_PER_US = 125
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alarm_raw,
  input  logic                 cfg_active_low,
  input  logic                 cfg_irq_en,
  input  logic [COUNT_W-1:0]   cfg_count_limit,
  input  logic [FILT_W-1:0]    cfg_filter_len,
  input  logic [HOLD_US_W-1:0] cfg_hold_us,
  input  logic                 irq_clear,
  output logic                 throttle_req,
  output logic                 irq
);
  oc_guard_pkg::oc_sense_t sense;
  logic sense_level, sense_rise;

  oc_alarm_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .alarm_raw(alarm_raw),
    .active_low(cfg_active_low), .sense(sense)
  );

  assign sense_level = sense.level;
  assign sense_rise  = sense.rise;

  oc_event_tally #(.COUNT_W(COUNT_W), .FILT_W(FILT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .rise(sense_rise), .irq_en(cfg_irq_en),
    .limit(cfg_count_limit), .filt_len(cfg_filter_len),
    .irq_clear(irq_clear), .irq(irq)
  );

  oc_throttle_hold #(.HOLD_US_W(HOLD_US_W), .CYC_PER_US(CYC_PER_US)) u_hold (
    .clk(clk), .rst_n(rst_n), .level(sense_level),
    .hold_us(cfg_hold_us), .throttle(throttle_req)
  );
endmodule

// File: rtl/oc_alarm_guard_chk.sv
module oc_alarm_guard_chk #(
  parameter int COUNT_W   = 8,
  parameter int HOLD_US_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_irq_en,
  input logic [COUNT_W-1:0]   cfg_count_limit,
  input logic [HOLD_US_W-1:0] cfg_hold_us,
  input logic                 irq_clear,
  input logic                 sense_level,
  input logic                 sense_rise,
  input logic                 throttle_req,
  input logic                 irq
);
  p_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sense_level |-> throttle_req);

  p_single_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sense_rise |=> !sense_rise);

  p_every_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sense_rise && cfg_irq_en && (cfg_count_limit == '0) |=> irq);

  p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en && !irq |=> !irq);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clear |=> irq);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clear && !sense_rise |=> !irq);

  p_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sense_level) && (cfg_hold_us != '0) |-> throttle_req);
endmodule

bind oc_alarm_guard oc_alarm_guard_chk #(.COUNT_W(COUNT_W), .HOLD_US_W(HOLD_US_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_irq_en(cfg_irq_en),
  .cfg_count_limit(cfg_count_limit), .cfg_hold_us(cfg_hold_us),
  .irq_clear(irq_clear), .sense_level(sense_level), .sense_rise(sense_rise),
  .throttle_req(throttle_req), .irq(irq)
);

// File: tb/oc_alarm_guard_tb.sv
module oc_alarm_guard_tb;
  localparam int COUNT_W = 8, FILT_W = 16, HOLD_US_W = 8, CPU = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst_n = 1'b0;
  logic                 alarm_raw = 1'b0;
  logic                 cfg_active_low = 1'b0;
  logic                 cfg_irq_en = 1'b0;
  logic [COUNT_W-1:0]   cfg_count_limit = '0;
  logic [FILT_W-1:0]    cfg_filter_len = '0;
  logic [HOLD_US_W-1:0] cfg_hold_us = '0;
  logic                 irq_clear = 1'b0;
  logic                 throttle_req, irq;

  oc_alarm_guard #(.COUNT_W(COUNT_W), .FILT_W(FILT_W), .HOLD_US_W(HOLD_US_W),
                   .CYC_PER_US(CPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .alarm_raw(alarm_raw),
    .cfg_active_low(cfg_active_low), .cfg_irq_en(cfg_irq_en),
    .cfg_count_limit(cfg_count_limit), .cfg_filter_len(cfg_filter_len),
    .cfg_hold_us(cfg_hold_us), .irq_clear(irq_clear),
    .throttle_req(throttle_req), .irq(irq)
  );

  // behavioural reference, updated at each rising edge
  int    m_cnt = 0, m_ft = 0, m_ht = 0;
  bit    m_irq = 0, p1 = 0, p2 = 0, pv = 0;
  int    checks = 0, fails = 0;
  bit    done = 0;
  string cur_req = "R9";

  always @(posedge clk) begin : ref_model
    bit evt;
    int base;
    bit birq;
    if (!rst_n) begin
      m_cnt = 0; m_ft = 0; m_ht = 0; m_irq = 0; p1 = 0; p2 = 0; pv = 0;
    end else begin
      evt  = p2 && !pv;
      base = irq_clear ? 0 : m_cnt;
      birq = irq_clear ? 1'b0 : m_irq;
      if (evt) begin
        if (base < 255) base = base + 1;
        m_ft = 0;
        if (cfg_irq_en && base >= int'(cfg_count_limit)) birq = 1;
      end else if (irq_clear) begin
        m_ft = 0;
      end else if (base != 0 && cfg_filter_len != 0) begin
        if (m_ft + 1 == int'(cfg_filter_len)) begin base = 0; m_ft = 0; end
        else m_ft = m_ft + 1;
      end
      m_cnt = base;
      m_irq = birq;
      if (p2) m_ht = int'(cfg_hold_us) * CPU;
      else if (m_ht > 0) m_ht = m_ht - 1;
      pv = p2; p2 = p1; p1 = alarm_raw ^ cfg_active_low;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks = checks + 2;
      if (throttle_req !== (p2 || m_ht != 0)) begin
        fails++;
        $display("FAIL %s throttle_req=%b expected %b at %0t", cur_req, throttle_req, (p2 || m_ht != 0), $time);
      end
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL %s irq=%b expected %b at %0t", cur_req, irq, m_irq, $time);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pulse(input int w, input int g);
    alarm_raw = ~cfg_active_low;
    step(w);
    alarm_raw = cfg_active_low;
    step(g);
  endtask

  task automatic clear_pulse();
    irq_clear = 1'b1; step(1); irq_clear = 1'b0; step(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    int lfsr;
    // R9: reset state
    cur_req = "R9";
    step(4);
    rst_n = 1'b1;
    step(3);
    // R1 / R2: active-high alarm, level tracking and latency
    cur_req = "R2";
    pulse(6, 8);
    cur_req = "R1";
    pulse(1, 6);
    // R8: release tail of 2 us
    cur_req = "R8";
    cfg_hold_us = 2;
    pulse(5, 12);
    cfg_hold_us = 1;
    pulse(3, 3); pulse(2, 10);
    cfg_hold_us = 0;
    // R1: active-low polarity
    cur_req = "R1";
    cfg_active_low = 1'b1; alarm_raw = 1'b1;
    step(6);
    pulse(4, 8);
    // R3: limit 3
    cur_req = "R3";
    cfg_irq_en = 1'b1; cfg_count_limit = 3;
    pulse(2, 4); pulse(2, 4); pulse(3, 6);
    step(4);
    // R6: sticky until cleared, clear restarts tally
    cur_req = "R6";
    step(5);
    clear_pulse();
    pulse(2, 4); pulse(2, 4);
    step(6);
    pulse(2, 6);
    clear_pulse();
    // R6: clear on the event cycle (event lands 2 edges after pin goes active)
    cfg_count_limit = 2;
    alarm_raw = ~cfg_active_low;
    step(2);
    irq_clear = 1'b1; step(1); irq_clear = 1'b0;
    step(3);
    alarm_raw = cfg_active_low; step(4);
    pulse(2, 6);
    clear_pulse();
    // R4: limit 0 fires on the first event
    cur_req = "R4";
    cfg_count_limit = 0;
    pulse(2, 6);
    clear_pulse();
    cfg_count_limit = 1;
    pulse(2, 6);
    clear_pulse();
    // R5: disabled interrupt, throttle still active
    cur_req = "R5";
    cfg_irq_en = 1'b0;
    repeat (4) pulse(2, 3);
    step(4);
    cfg_irq_en = 1'b1;
    clear_pulse();
    // R7: quiet window of 10 clocks
    cur_req = "R7";
    cfg_count_limit = 3; cfg_filter_len = 10;
    pulse(2, 14); pulse(2, 14); pulse(2, 14); pulse(2, 14);
    pulse(2, 5); pulse(2, 5); pulse(2, 8);
    clear_pulse();
    pulse(2, 7); pulse(2, 7); pulse(2, 9);
    clear_pulse();
    cfg_filter_len = 0;
    pulse(2, 40); pulse(2, 40); pulse(2, 8);
    clear_pulse();
    // mixed pseudo-random traffic
    cur_req = "R3";
    cfg_filter_len = 7; cfg_count_limit = 2; cfg_hold_us = 1; cfg_active_low = 1'b0;
    lfsr = 32'h1ACE;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[2:0] == 3'd0) alarm_raw = ~alarm_raw;
      irq_clear = (lfsr[9:4] == 6'd0);
      step(1);
    end
    irq_clear = 1'b0;
    step(10);
    finish_run();
  end
endmodule